// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Comparator

This unit sits beside the fetch and memory stages of a 32-bit processor and flags debug events. It holds four instruction breakpoint registers, four data watchpoint registers and one debug control word. Software loads them through a register write port that carries a select code, a slot index and a 32-bit data word. The same select and index also drive a combinational readback mux.

In every cycle the unit compares the fetch program counter against the enabled breakpoints. It also compares the current load or store against the armed watchpoints. A breakpoint is enabled by bit 0 of its own register. A watchpoint is armed by a 2-bit type field in the debug control word, and that field also sets which access direction it watches. On a watchpoint hit the unit withdraws the commit permission of the access in the same cycle, so the matching store never reaches memory. Exception vectoring and pipeline flush are handled by the consumer of the hit outputs.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every breakpoint, watchpoint and control register reads back as zero, and no hit is reported.
- R2: Select code 1 addresses breakpoint slots. The written word is stored unchanged and reads back unchanged, and bit 0 is the enable. Select 0 is the control word, select 2 the watchpoint slots, and select 3 reads as zero.
- R3: An enabled breakpoint reports a hit when the fetch PC is valid and equals its stored word with bit 0 cleared. A disabled breakpoint never hits.
- R4: The type of watchpoint slot i sits in control bits [2i+3:2i+2], so slot 0 uses bits 3:2 and slot 3 uses bits 9:8. The encoding is 0 off, 1 loads, 2 stores, 3 both.
- R5: A watchpoint never matches an access whose direction its type excludes.
- R6: A data access matches when its byte range covers the stored watch address. The range starts at the access address and is 1, 2 or 4 bytes long for size codes 0, 1 and 2; size code 3 counts as 4 bytes.
- R7: The commit output equals mem_valid_i except in a cycle with a watchpoint hit, where it is low.
- R8: A breakpoint or watchpoint write with index 4 or more changes no register, and such an index reads back as zero.
- R9: The hit index is the lowest-numbered matching slot. When both a breakpoint and a watchpoint match in one cycle, only wp_hit_o is raised and the index is that of the watchpoint.
- R10: A register write in cycle N affects matching and readback from cycle N+1 onward, not in cycle N.
- R11: Rewriting the control word arms or disarms each watchpoint at its stored address. Rewriting a watchpoint address keeps that slot's current type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 2 | Register group: 0 control, 1 breakpoint, 2 watchpoint, 3 none |
| csr_idx_i | input | 3 | Slot index within the group |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Readback of the selected register |
| pc_valid_i | input | 1 | Fetch PC is valid |
| pc_i | input | 32 | Fetch program counter |
| mem_valid_i | input | 1 | Data access present |
| mem_we_i | input | 1 | Data access is a store |
| mem_addr_i | input | 32 | Data access byte address |
| mem_size_i | input | 2 | Access size code: 0 byte, 1 half, 2 or 3 word |
| bp_hit_o | output | 1 | Breakpoint exception request |
| wp_hit_o | output | 1 | Watchpoint exception request |
| hit_idx_o | output | 2 | Slot index of the reported hit |
| mem_commit_o | output | 1 | Access may take effect |

## Verification
The assertions check on every cycle that a watchpoint outranks a breakpoint and vetoes the commit. They also check that a breakpoint hit only occurs on a valid even PC, that no slot matches against its direction type, and that out-of-range writes leave the slot registers untouched. The bench's scenarios are needed for the rest: address and range arithmetic at the edges of word, half and byte spans, re-arming through control rewrites with stored addresses, the one-cycle delay between a write and its effect, and lowest-index selection when slots overlap.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_BRK   = 2'd1,
    SEL_WATCH = 2'd2,
    SEL_NONE  = 2'd3
  } csr_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/dbg_csr_regs.sv
module dbg_csr_regs
  import dbg_match_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned SLOTS = 4,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [1:0]                sel_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [AW-1:0]             wdata_i,
  output logic [AW-1:0]             rdata_o,
  output logic [SLOTS-1:0][AW-1:0]  brk_q_o,
  output logic [SLOTS-1:0][AW-1:0]  watch_q_o,
  output logic [2*SLOTS-1:0]        kinds_o
);
  logic [AW-1:0]     ctrl_q;
  logic              idx_ok;
  logic [SLOT_W-1:0] slot;

  assign idx_ok = 32'(idx_i) < SLOTS;
  assign slot   = idx_i[SLOT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && sel_i == SEL_CTRL) ctrl_q <= wdata_i;
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        brk_q_o[i]   <= '0;
        watch_q_o[i] <= '0;
      end else if (we_i && idx_ok && slot == SLOT_W'(i)) begin
        if (sel_i == SEL_BRK)   brk_q_o[i]   <= wdata_i;
        if (sel_i == SEL_WATCH) watch_q_o[i] <= wdata_i;
      end
    end
  end

  // type field of slot i lives at bits [2i+3:2i+2]
  assign kinds_o = ctrl_q[2*SLOTS+1:2];

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_CTRL:  rdata_o = ctrl_q;
      SEL_BRK:   if (idx_ok) rdata_o = brk_q_o[slot];
      SEL_WATCH: if (idx_ok) rdata_o = watch_q_o[slot];
      default:   rdata_o = '0;
    endcase
  end

  // R8
  bad_idx_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !idx_ok && (sel_i == SEL_BRK || sel_i == SEL_WATCH))
      |=> ($stable(brk_q_o) && $stable(watch_q_o)));
endmodule

// File: rtl/dbg_bp_cmp.sv
module dbg_bp_cmp #(
  parameter int unsigned AW    = 32,
  parameter int unsigned SLOTS = 4,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SLOTS-1:0][AW-1:0] brk_q_i,
  input  logic                     pc_valid_i,
  input  logic [AW-1:0]            pc_i,
  output logic                     hit_o,
  output logic [SLOT_W-1:0]        idx_o
);
  logic [SLOTS-1:0] match;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign match[i] = pc_valid_i && brk_q_i[i][0] && (pc_i == {brk_q_i[i][AW-1:1], 1'b0});
  end

  always_comb begin
    idx_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--) if (match[i]) idx_o = SLOT_W'(i);
  end
  assign hit_o = |match;

  // R3
  bp_needs_even_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (pc_valid_i && !pc_i[0]));
endmodule

// File: rtl/dbg_wp_cmp.sv
module dbg_wp_cmp
  import dbg_match_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned SLOTS = 4,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SLOTS-1:0][AW-1:0] watch_q_i,
  input  logic [2*SLOTS-1:0]       kinds_i,
  input  logic                     mem_valid_i,
  input  logic                     mem_we_i,
  input  logic [AW-1:0]            mem_addr_i,
  input  logic [1:0]               mem_size_i,
  output logic                     hit_o,
  output logic [SLOT_W-1:0]        idx_o
);
  logic [AW-1:0]    span;
  logic [SLOTS-1:0] match;

  always_comb begin
    case (mem_size_i)
      SZ_BYTE: span = AW'(1);
      SZ_HALF: span = AW'(2);
      default: span = AW'(4);
    endcase
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    logic [1:0]    kind;
    logic          dir_ok;
    logic [AW-1:0] offs;
    assign kind   = kinds_i[2*i+:2];
    assign dir_ok = mem_we_i ? kind[1] : kind[0];
    assign offs   = watch_q_i[i] - mem_addr_i;  // wraps modulo 2^AW
    assign match[i] = mem_valid_i && dir_ok && (offs < span);

    // R5
    wp_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match[i] |-> (mem_we_i ? kinds_i[2*i+1] : kinds_i[2*i]));
  end

  always_comb begin
    idx_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--) if (match[i]) idx_o = SLOT_W'(i);
  end
  assign hit_o = |match;
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit #(
  parameter int unsigned AW    = 32,
  parameter int unsigned SLOTS = 4,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_we_i,
  input  logic [1:0]        csr_sel_i,
  input  logic [IDX_W-1:0]  csr_idx_i,
  input  logic [AW-1:0]     csr_wdata_i,
  output logic [AW-1:0]     csr_rdata_o,
  input  logic              pc_valid_i,
  input  logic [AW-1:0]     pc_i,
  input  logic              mem_valid_i,
  input  logic              mem_we_i,
  input  logic [AW-1:0]     mem_addr_i,
  input  logic [1:0]        mem_size_i,
  output logic              bp_hit_o,
  output logic              wp_hit_o,
  output logic [SLOT_W-1:0] hit_idx_o,
  output logic              mem_commit_o
);
  logic [SLOTS-1:0][AW-1:0] brk_q, watch_q;
  logic [2*SLOTS-1:0]       kinds;
  logic                     bp_any, wp_any;
  logic [SLOT_W-1:0]        bp_idx, wp_idx;

  dbg_csr_regs #(.AW(AW), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(csr_we_i), .sel_i(csr_sel_i), .idx_i(csr_idx_i),
    .wdata_i(csr_wdata_i), .rdata_o(csr_rdata_o),
    .brk_q_o(brk_q), .watch_q_o(watch_q), .kinds_o(kinds)
  );

  dbg_bp_cmp #(.AW(AW), .SLOTS(SLOTS)) u_bp (
    .clk_i, .rst_ni, .brk_q_i(brk_q),
    .pc_valid_i, .pc_i, .hit_o(bp_any), .idx_o(bp_idx)
  );

  dbg_wp_cmp #(.AW(AW), .SLOTS(SLOTS)) u_wp (
    .clk_i, .rst_ni, .watch_q_i(watch_q), .kinds_i(kinds),
    .mem_valid_i, .mem_we_i, .mem_addr_i, .mem_size_i,
    .hit_o(wp_any), .idx_o(wp_idx)
  );

  assign wp_hit_o     = wp_any;
  assign bp_hit_o     = bp_any && !wp_any;
  assign hit_idx_o    = wp_any ? wp_idx : bp_idx;
  assign mem_commit_o = mem_valid_i && !wp_any;

  // R9
  wp_over_bp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_any && wp_any) |-> (wp_hit_o && !bp_hit_o && hit_idx_o == wp_idx));

  // R7
  wp_blocks_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_hit_o |-> !mem_commit_o);

  // R9
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bp_hit_o && wp_hit_o));
endmodule

// File: tb/dbg_match_unit_test.sv
module dbg_match_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = 2'd3;
  logic [2:0]  csr_idx = 3'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        pc_valid = 1'b0;
  logic [31:0] pc = '0;
  logic        mem_valid = 1'b0;
  logic        mem_we = 1'b0;
  logic [31:0] mem_addr = '0;
  logic [1:0]  mem_size = 2'd0;
  logic        bp_hit, wp_hit, commit;
  logic [1:0]  hit_idx;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] m_bp [4];
  logic [31:0] m_wp [4];
  logic [31:0] m_dc;

  always #2 clk = ~clk;  // 250 MHz

  dbg_match_unit uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .csr_we_i(csr_we), .csr_sel_i(csr_sel), .csr_idx_i(csr_idx),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
    .pc_valid_i(pc_valid), .pc_i(pc),
    .mem_valid_i(mem_valid), .mem_we_i(mem_we), .mem_addr_i(mem_addr), .mem_size_i(mem_size),
    .bp_hit_o(bp_hit), .wp_hit_o(wp_hit), .hit_idx_o(hit_idx), .mem_commit_o(commit)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock: compare against the model before the edge, update the model after it
  task automatic step(input string tag);
    int  e_bi, e_wi, len, typ;
    bit  e_bp, e_wp, dir;
    longint unsigned off;
    logic [31:0] e_rd;
    @(negedge clk);
    #1;
    e_bp = 0; e_wp = 0; e_bi = 0; e_wi = 0;
    for (int i = 3; i >= 0; i--)
      if (pc_valid && m_bp[i][0] == 1'b1 && pc == (m_bp[i] & 32'hFFFF_FFFE)) begin
        e_bp = 1; e_bi = i;
      end
    len = (mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4;
    for (int i = 3; i >= 0; i--) begin
      typ = int'((m_dc >> (2 * i + 2)) & 32'd3);
      dir = mem_we ? (typ >= 2) : (typ == 1 || typ == 3);
      off = (longint'(m_wp[i]) - longint'(mem_addr)) & 64'hFFFF_FFFF;
      if (mem_valid && dir && off < longint'(len)) begin
        e_wp = 1; e_wi = i;
      end
    end
    case (csr_sel)
      2'd0: e_rd = m_dc;
      2'd1: e_rd = (csr_idx < 4) ? m_bp[csr_idx[1:0]] : 32'd0;
      2'd2: e_rd = (csr_idx < 4) ? m_wp[csr_idx[1:0]] : 32'd0;
      default: e_rd = 32'd0;
    endcase
    chk(tag, "wp_hit", wp_hit, e_wp);
    chk(tag, "bp_hit", bp_hit, e_bp && !e_wp);
    if (e_wp)      chk(tag, "hit_idx(wp)", hit_idx, e_wi);
    else if (e_bp) chk(tag, "hit_idx(bp)", hit_idx, e_bi);
    chk(tag, "commit", commit, mem_valid && !e_wp);
    chk(tag, "rdata", csr_rdata, e_rd);
    @(posedge clk);
    if (rst_ni && csr_we) begin
      if (csr_sel == 2'd0) m_dc = csr_wdata;
      else if (csr_sel == 2'd1 && csr_idx < 4) m_bp[csr_idx[1:0]] = csr_wdata;
      else if (csr_sel == 2'd2 && csr_idx < 4) m_wp[csr_idx[1:0]] = csr_wdata;
    end
    #1;
  endtask

  task automatic quiet();
    csr_we = 0; csr_sel = 2'd3; csr_idx = 0; csr_wdata = 0;
    pc_valid = 0; mem_valid = 0; mem_we = 0; mem_size = 0;
  endtask

  task automatic wr(input string tag, input logic [1:0] s, input logic [2:0] i, input logic [31:0] d);
    quiet(); csr_we = 1; csr_sel = s; csr_idx = i; csr_wdata = d;
    step(tag);
    csr_we = 0;
  endtask

  task automatic rd(input string tag, input logic [1:0] s, input logic [2:0] i);
    quiet(); csr_sel = s; csr_idx = i;
    step(tag);
  endtask

  task automatic fetch(input string tag, input logic [31:0] a);
    quiet(); pc_valid = 1; pc = a;
    step(tag);
  endtask

  task automatic acc(input string tag, input logic w, input logic [31:0] a, input logic [1:0] sz);
    quiet(); mem_valid = 1; mem_we = w; mem_addr = a; mem_size = sz;
    step(tag);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_bp[i] = '0; m_wp[i] = '0; end
    m_dc = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #1;

    // R1: reset state
    rd("R1", 2'd0, 0);
    for (int i = 0; i < 4; i++) begin rd("R1", 2'd1, 3'(i)); rd("R1", 2'd2, 3'(i)); end
    fetch("R1", 32'h0);
    acc("R1", 1, 32'h0, 2'd2);

    // R2/R3: enable bit, stored word as written
    wr("R2", 2'd1, 0, 32'h0000_1001);
    rd("R2", 2'd1, 0);
    fetch("R3", 32'h0000_1000);
    fetch("R3", 32'h0000_1001);
    fetch("R3", 32'h0000_1004);
    wr("R2", 2'd1, 1, 32'h0000_2000);
    fetch("R2", 32'h0000_2000);
    rd("R2", 2'd3, 0);

    // R10: write and fetch in the same cycle
    quiet(); csr_we = 1; csr_sel = 2'd1; csr_idx = 2; csr_wdata = 32'h0000_3001;
    pc_valid = 1; pc = 32'h0000_3000;
    step("R10");
    csr_we = 0;
    step("R10");

    // R8: out-of-range slot writes
    wr("R8", 2'd1, 5, 32'h0000_4001);
    fetch("R8", 32'h0000_4000);
    rd("R8", 2'd1, 5);
    wr("R8", 2'd2, 4, 32'h0000_0500);
    rd("R8", 2'd2, 4);
    for (int i = 0; i < 4; i++) rd("R8", 2'd1, 3'(i));

    // R4/R5: slot 0 types
    wr("R4", 2'd2, 0, 32'h0000_0100);
    acc("R4", 0, 32'h100, 2'd0);
    wr("R4", 2'd0, 0, 32'h0000_0004);
    acc("R5", 0, 32'h100, 2'd0);
    acc("R5", 1, 32'h100, 2'd0);
    wr("R4", 2'd0, 0, 32'h0000_0008);
    acc("R5", 0, 32'h100, 2'd0);
    acc("R7", 1, 32'h100, 2'd0);
    wr("R4", 2'd0, 0, 32'h0000_000C);
    acc("R5", 0, 32'h100, 2'd0);
    acc("R7", 1, 32'h100, 2'd0);
    acc("R7", 1, 32'h104, 2'd0);

    // R4/R6: slot 3 via bits 9:8, range coverage
    wr("R6", 2'd2, 3, 32'h0000_0200);
    wr("R4", 2'd0, 0, 32'h0000_0300);
    acc("R6", 0, 32'h1FD, 2'd2);
    acc("R6", 1, 32'h1FC, 2'd2);
    acc("R6", 1, 32'h1FF, 2'd1);
    acc("R6", 1, 32'h1FE, 2'd1);
    acc("R6", 0, 32'h201, 2'd0);
    acc("R6", 0, 32'h1FE, 2'd3);
    acc("R4", 0, 32'h100, 2'd0);

    // R11: disarm, re-arm, move address keeping type
    wr("R11", 2'd0, 0, 32'h0000_0000);
    acc("R11", 1, 32'h200, 2'd0);
    wr("R11", 2'd0, 0, 32'h0000_0200);
    acc("R11", 0, 32'h200, 2'd0);
    acc("R11", 1, 32'h200, 2'd0);
    wr("R11", 2'd2, 3, 32'h0000_0600);
    acc("R11", 0, 32'h200, 2'd0);
    acc("R11", 0, 32'h600, 2'd0);
    acc("R11", 1, 32'h600, 2'd0);

    // R9: lowest index and watchpoint priority
    wr("R9", 2'd2, 0, 32'h0000_0600);
    wr("R9", 2'd0, 0, 32'h0000_030C);
    acc("R9", 1, 32'h600, 2'd0);
    wr("R9", 2'd1, 3, 32'h0000_1001);
    fetch("R9", 32'h0000_1000);
    quiet(); pc_valid = 1; pc = 32'h0000_1000; mem_valid = 1; mem_we = 0; mem_addr = 32'h600;
    step("R9");
    mem_addr = 32'h700;
    step("R9");

    // R7: access with no watchpoint still commits
    acc("R7", 1, 32'h0000_8000, 2'd2);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule